// File: doc/BRIEF.md
# Multi-Channel ADC Threshold Monitor

This block watches up to eight channels, each backed by a channel of an external ADC, and flags any sample that leaves a programmed window. Each monitor channel has its own eight-byte register slot. The slot holds the ADC channel to sample, a lower and an upper 16-bit limit, a choice among three shared interval timers, a control byte, and an enable byte. When a channel's timer expires, the block asks the ADC for one conversion through a request/acknowledge handshake. It then compares the returned code with both limits.

A code strictly under the lower limit sets the channel's bit in the low-status byte. A code strictly over the upper limit sets its bit in the high-status byte. Both status bytes are sticky and are cleared by writing ones. The level interrupt is the OR, over all channels, of each set status bit that is qualified by both the channel's measurement enable and the interrupt enable for that direction. Software sets up the slots, sets the global enable, and then writes the start request. After that, sampling proceeds on the timebase tick without further action.

Top module: `thmon_top`

## Requirements
- R1: Channel n's slot is at byte address 0x60+8n. Its bytes are, by offset: 0 ADC select, 1/2 lower limit low/high byte, 3/4 upper limit low/high byte, 5 interval select (bits 1:0), 6 control, 7 enable. Every slot byte reads back what was written. Address 0x0F reads the number of channels. After reset, 0x44 reads 0x03 and 0x45 reads 0xA4.
- R2: No ADC request is issued unless two things are true: address 0x46 bit 7 (global enable) is set, and a write with bit 7 set has been made to 0x47 (start) since the global enable was last cleared. Writing 0x46 with bit 7 clear stops monitoring and drops the start.
- R3: Interval select 0, 1 and 2 choose timers 1, 2 and 3, and value 3 means the channel is never sampled. Timer 1 uses the code in 0x44. Timer 2 uses the code in 0x45 bits 7:4, and timer 3 uses 0x45 bits 3:0. A timer with code c fires on every (c+1)-th tick, counted from the start of monitoring.
- R4: Channels that are due are served one ADC request at a time, in ascending channel order. While a request is outstanding, the block presents the channel's ADC select byte, the settle field (control bits 3:0) and the calibration field (control bits 5:4).
- R5: A returned code strictly below the lower limit sets bit n of the low-status byte at 0x0A. A code equal to the limit sets nothing.
- R6: A returned code strictly above the upper limit sets bit n of the high-status byte at 0x0B. A code equal to the limit sets nothing.
- R7: Status bits stay set until a 1 is written to that bit position. Writing 0 leaves them unchanged.
- R8: The interrupt is high exactly when some channel has enable bit 7 (measure) set together with either a low status bit and enable bit 0, or a high status bit and enable bit 1.
- R9: A channel whose measurement enable (enable bit 7) is clear is never requested, even when its timer fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| tick | input | 1 | Timebase tick, one cycle per unit |
| adc_req | output | 1 | Conversion request, held until acknowledged |
| adc_sel | output | 8 | ADC channel to convert |
| adc_settle | output | 4 | Settle-delay field for the conversion |
| adc_cal | output | 2 | Calibration-select field for the conversion |
| adc_ack | input | 1 | One-cycle conversion done, code valid |
| adc_code | input | 16 | Conversion result |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is several channels on different timers falling due on the same tick. That is where the ascending service order and the one-at-a-time handshake matter. The timer codes are set to 0, 1 and 2, so the tick periods are 1, 2 and 3. Six ticks then give every combination, including one tick where all three timers fire together. The order of requests captured at the ADC model is compared against the order computed from the tick number. The sampled codes are chosen to land below, above and exactly on the limits. The enable bytes are then stepped one at a time to walk the interrupt through each gating term.

// File: rtl/thmon_pkg.sv
// Shared constants for the threshold monitor.
// Assumes byte-wide register addressing and 16-bit ADC codes.
package thmon_pkg;
    localparam int          THR_W   = 16;
    localparam logic [7:0]  A_STLO  = 8'h0A;
    localparam logic [7:0]  A_STHI  = 8'h0B;
    localparam logic [7:0]  A_AVAIL = 8'h0F;
    localparam logic [7:0]  A_TMR1  = 8'h44;
    localparam logic [7:0]  A_TMR23 = 8'h45;
    localparam logic [7:0]  A_GEN   = 8'h46;
    localparam logic [7:0]  A_START = 8'h47;
    localparam logic [7:0]  A_SLOT  = 8'h60;
    localparam logic [1:0]  IVAL_OFF = 2'd3;

    typedef enum logic {S_IDLE, S_WAIT} sched_st_t;
endpackage

// File: rtl/thmon_regs.sv
// Register file: global controls, per-channel 8-byte slots, W1C status.
// Assumes NCH <= 8, so each status byte covers all channels, and that
// the slot range fits below address 0x100.
module thmon_regs
    import thmon_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [7:0]                 addr,
    input  logic [7:0]                 wdata,
    output logic [7:0]                 rdata,
    input  logic [NCH-1:0]             set_lo,
    input  logic [NCH-1:0]             set_hi,
    output logic [NCH-1:0]             st_lo,
    output logic [NCH-1:0]             st_hi,
    output logic [NCH-1:0]             meas_en,
    output logic [NCH-1:0]             lo_ie,
    output logic [NCH-1:0]             hi_ie,
    output logic                       active,
    output logic [7:0]                 tmr1_code,
    output logic [3:0]                 tmr2_code,
    output logic [3:0]                 tmr3_code,
    output logic [NCH-1:0][7:0]        ch_sel,
    output logic [NCH-1:0][7:0]        ctl,
    output logic [NCH-1:0][1:0]        ival,
    output logic [NCH-1:0][THR_W-1:0]  lo_thr,
    output logic [NCH-1:0][THR_W-1:0]  hi_thr
);
    localparam int IW       = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int SLOT_END = 'h60 + 8 * NCH;

    logic [NCH-1:0][7:0][7:0] slot_q;
    logic [7:0]               tmr1_q, tmr23_q;
    logic                     gen_q, started_q;
    logic [7:0]               off;
    logic [IW-1:0]            idx;
    logic                     in_slot;

    assign off     = addr - A_SLOT;
    assign idx     = off[IW+2:3];
    assign in_slot = (addr >= A_SLOT) && ({1'b0, addr} < 9'(SLOT_END));

    // Slot storage: byte writes into the addressed channel slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= '0;
        else if (we && in_slot)
            slot_q[idx][addr[2:0]] <= wdata;
    end

    // Global timer codes, enable and start latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr1_q    <= 8'h03;
            tmr23_q   <= 8'hA4;
            gen_q     <= 1'b0;
            started_q <= 1'b0;
        end else if (we) begin
            if (addr == A_TMR1)  tmr1_q  <= wdata;
            if (addr == A_TMR23) tmr23_q <= wdata;
            if (addr == A_GEN) begin
                gen_q <= wdata[7];
                if (!wdata[7]) started_q <= 1'b0;
            end
            if (addr == A_START && wdata[7] && gen_q) started_q <= 1'b1;
        end
    end

    // Sticky status: a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_lo <= '0;
            st_hi <= '0;
        end else begin
            st_lo <= (st_lo & ~((we && addr == A_STLO) ? wdata[NCH-1:0] : '0)) | set_lo;
            st_hi <= (st_hi & ~((we && addr == A_STHI) ? wdata[NCH-1:0] : '0)) | set_hi;
        end
    end

    // Field extraction from each slot.
    for (genvar n = 0; n < NCH; n++) begin : g_fields
        assign ch_sel[n]  = slot_q[n][0];
        assign lo_thr[n]  = {slot_q[n][2], slot_q[n][1]};
        assign hi_thr[n]  = {slot_q[n][4], slot_q[n][3]};
        assign ival[n]    = slot_q[n][5][1:0];
        assign ctl[n]     = slot_q[n][6];
        assign meas_en[n] = slot_q[n][7][7];
        assign hi_ie[n]   = slot_q[n][7][1];
        assign lo_ie[n]   = slot_q[n][7][0];
    end

    assign active    = gen_q && started_q;
    assign tmr1_code = tmr1_q;
    assign tmr2_code = tmr23_q[7:4];
    assign tmr3_code = tmr23_q[3:0];

    // Read mux.
    always_comb begin
        rdata = 8'h00;
        if (in_slot)
            rdata = slot_q[idx][addr[2:0]];
        else begin
            case (addr)
                A_STLO:  rdata = 8'(st_lo);
                A_STHI:  rdata = 8'(st_hi);
                A_AVAIL: rdata = 8'(NCH);
                A_TMR1:  rdata = tmr1_q;
                A_TMR23: rdata = tmr23_q;
                A_GEN:   rdata = {gen_q, 7'b0};
                A_START: rdata = {started_q, 7'b0};
                default: rdata = 8'h00;
            endcase
        end
    end

    // R7: without a write to the status address no low bit may drop
    assert_lo_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == A_STLO) |=> ((st_lo & $past(st_lo)) == $past(st_lo)));
    // R7: same for the high status byte
    assert_hi_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == A_STHI) |=> ((st_hi & $past(st_hi)) == $past(st_hi)));
endmodule

// File: rtl/thmon_ticker.sv
// One interval timer: counts ticks while monitoring runs and fires on
// every (code+1)-th tick. The count restarts whenever monitoring stops.
// A code lowered below the current count fires on the next tick.
module thmon_ticker #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] code,
    output logic         fire
);
    logic [W-1:0] cnt_q;

    assign fire = run && tick && (cnt_q >= code);

    // Tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (fire)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/thmon_sched.sv
// Due tracking, ascending-order arbitration and the ADC handshake.
// Issues one request at a time. Assumes adc_ack is a single-cycle
// pulse that arrives only while adc_req is high.
module thmon_sched
    import thmon_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       active,
    input  logic [2:0]                 fire,
    input  logic [NCH-1:0]             meas_en,
    input  logic [NCH-1:0][1:0]        ival,
    input  logic [NCH-1:0][7:0]        ch_sel,
    input  logic [NCH-1:0][7:0]        ctl,
    input  logic [NCH-1:0][THR_W-1:0]  lo_thr,
    input  logic [NCH-1:0][THR_W-1:0]  hi_thr,
    input  logic                       adc_ack,
    input  logic [THR_W-1:0]           adc_code,
    output logic                       adc_req,
    output logic [7:0]                 adc_sel,
    output logic [3:0]                 adc_settle,
    output logic [1:0]                 adc_cal,
    output logic [NCH-1:0]             set_lo,
    output logic [NCH-1:0]             set_hi
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    sched_st_t      st_q;
    logic [IW-1:0]  cur_q, pick;
    logic           pick_v;
    logic [NCH-1:0] due_q;
    logic [3:0]     fire4;
    logic           done;

    assign fire4 = {1'b0, fire};
    assign done  = (st_q == S_WAIT) && adc_ack;

    // Lowest-numbered due channel.
    always_comb begin
        pick   = '0;
        pick_v = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (due_q[i]) begin
                pick   = IW'(i);
                pick_v = 1'b1;
            end
        end
    end

    // Per-channel due flags: set by the selected timer, cleared on service.
    always_ff @(posedge clk) begin
        if (!rst_n)
            due_q <= '0;
        else begin
            for (int n = 0; n < NCH; n++) begin
                if (!meas_en[n] || ival[n] == IVAL_OFF)
                    due_q[n] <= 1'b0;
                else if (active && fire4[ival[n]])
                    due_q[n] <= 1'b1;
                else if (done && cur_q == IW'(n))
                    due_q[n] <= 1'b0;
            end
        end
    end

    // Request state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cur_q <= '0;
        end else if (st_q == S_IDLE) begin
            if (active && pick_v) begin
                st_q  <= S_WAIT;
                cur_q <= pick;
            end
        end else if (adc_ack)
            st_q <= S_IDLE;
    end

    assign adc_req    = (st_q == S_WAIT);
    assign adc_sel    = ch_sel[cur_q];
    assign adc_settle = ctl[cur_q][3:0];
    assign adc_cal    = ctl[cur_q][5:4];

    // Window compare on the acknowledged code.
    always_comb begin
        set_lo = '0;
        set_hi = '0;
        if (done && meas_en[cur_q]) begin
            set_lo[cur_q] = adc_code < lo_thr[cur_q];
            set_hi[cur_q] = adc_code > hi_thr[cur_q];
        end
    end

    // R4: an outstanding request keeps its channel until acknowledged
    assert_hold_chan_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && !adc_ack) |=> (adc_req && $stable(cur_q)));
    // R2: nothing starts while monitoring is inactive
    assert_no_req_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !adc_req) |=> !adc_req);
endmodule

// File: rtl/thmon_top.sv
// Top level of the threshold monitor. It ties the register file, three
// interval timers, the scheduler and the interrupt qualification together.
module thmon_top
    import thmon_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        tick,
    output logic        adc_req,
    output logic [7:0]  adc_sel,
    output logic [3:0]  adc_settle,
    output logic [1:0]  adc_cal,
    input  logic        adc_ack,
    input  logic [15:0] adc_code,
    output logic        irq
);
    logic [NCH-1:0]             st_lo, st_hi, meas_en, lo_ie, hi_ie, set_lo, set_hi;
    logic                       active;
    logic [7:0]                 tmr1_code;
    logic [3:0]                 tmr2_code, tmr3_code;
    logic [NCH-1:0][7:0]        ch_sel, ctl;
    logic [NCH-1:0][1:0]        ival;
    logic [NCH-1:0][THR_W-1:0]  lo_thr, hi_thr;
    logic [2:0][7:0]            codes;
    logic [2:0]                 fire;

    thmon_regs #(.NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .set_lo(set_lo), .set_hi(set_hi), .st_lo(st_lo),
        .st_hi(st_hi), .meas_en(meas_en), .lo_ie(lo_ie), .hi_ie(hi_ie),
        .active(active), .tmr1_code(tmr1_code), .tmr2_code(tmr2_code),
        .tmr3_code(tmr3_code), .ch_sel(ch_sel), .ctl(ctl), .ival(ival),
        .lo_thr(lo_thr), .hi_thr(hi_thr)
    );

    assign codes = {{4'b0, tmr3_code}, {4'b0, tmr2_code}, tmr1_code};

    for (genvar k = 0; k < 3; k++) begin : g_tmr
        thmon_ticker #(.W(8)) u_tmr (
            .clk(clk), .rst_n(rst_n), .run(active), .tick(tick),
            .code(codes[k]), .fire(fire[k])
        );
    end

    thmon_sched #(.NCH(NCH)) u_sched (
        .clk(clk), .rst_n(rst_n), .active(active), .fire(fire),
        .meas_en(meas_en), .ival(ival), .ch_sel(ch_sel), .ctl(ctl),
        .lo_thr(lo_thr), .hi_thr(hi_thr), .adc_ack(adc_ack), .adc_code(adc_code),
        .adc_req(adc_req), .adc_sel(adc_sel), .adc_settle(adc_settle),
        .adc_cal(adc_cal), .set_lo(set_lo), .set_hi(set_hi)
    );

    // Interrupt: OR of qualified per-channel conditions.
    assign irq = |(meas_en & ((st_lo & lo_ie) | (st_hi & hi_ie)));

    // R8: with both status bytes clear the interrupt must be low
    assert_irq_needs_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_lo == '0 && st_hi == '0) |-> !irq);
endmodule

// File: tb/tb_thmon_top.sv
module tb_thmon_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        tick = 1'b0;
    logic        adc_req;
    logic [7:0]  adc_sel;
    logic [3:0]  adc_settle;
    logic [1:0]  adc_cal;
    logic        adc_ack = 1'b0;
    logic [15:0] adc_code = 16'h0;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    int ord[0:255];
    int ord_n = 0;
    int req_cnt[0:7];
    int fld_bad = 0;
    int en_b[0:7];
    int t_num = 0;
    int slo = 0, shi = 0;

    always #10 clk = ~clk;

    thmon_top dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
        .adc_req(adc_req), .adc_sel(adc_sel), .adc_settle(adc_settle),
        .adc_cal(adc_cal), .adc_ack(adc_ack), .adc_code(adc_code), .irq(irq)
    );

    function automatic int lo_of(int n); return 1000 + 100 * n; endfunction
    function automatic int hi_of(int n); return 3000 + 100 * n; endfunction
    function automatic int ival_of(int n); return n % 4; endfunction
    function automatic int ctl_of(int n); return ((n % 4) << 4) | (15 - n); endfunction
    function automatic int code_of(int k);
        case (k)
            0: return 999;  1: return 1100; 2: return 3201; 4: return 3400;
            5: return 500;  6: return 5000; default: return 0;
        endcase
    endfunction
    function automatic bit exp_irq();
        bit r = 0;
        for (int n = 0; n < 8; n++)
            if (en_b[n][7] && ((slo[n] && en_b[n][0]) || (shi[n] && en_b[n][1]))) r = 1;
        return r;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(int a, int exp, string req);
        @(negedge clk);
        reg_addr = 8'(a);
        #1;
        chk(int'(reg_rdata) == exp, req, int'(reg_rdata), exp);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (30) @(negedge clk);
    endtask

    // ADC model: acknowledges each request at a falling edge and logs it.
    initial begin
        for (int i = 0; i < 8; i++) req_cnt[i] = 0;
        forever begin
            @(negedge clk);
            if (adc_req && !adc_ack) begin
                automatic int k = int'(adc_sel) - 'h20;
                if (k >= 0 && k < 8) begin
                    ord[ord_n % 256] = k;
                    ord_n++;
                    req_cnt[k]++;
                    if (int'(adc_settle) != (ctl_of(k) & 15) || int'(adc_cal) != ((ctl_of(k) >> 4) & 3))
                        fld_bad++;
                end
                adc_code = 16'(code_of(k));
                adc_ack  = 1'b1;
            end else
                adc_ack = 1'b0;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state, R1.
        rd_chk('h0F, 8, "R1 avail");
        rd_chk('h44, 3, "R1 tmr1 default");
        rd_chk('h45, 'hA4, "R1 tmr23 default");
        rd_chk('h0A, 0, "R7 status reset");
        chk(irq == 1'b0, "R8 irq reset", int'(irq), 0);
        chk(adc_req == 1'b0, "R2 req reset", int'(adc_req), 0);

        // Program all slots and timers (periods 1, 2, 3 ticks).
        wr('h44, 0);
        wr('h45, 'h12);
        for (int n = 0; n < 8; n++) begin
            automatic int b = 'h60 + 8 * n;
            en_b[n] = (n == 6) ? 'h80 : 'h83;
            wr(b + 0, 'h20 + n);
            wr(b + 1, lo_of(n) & 255); wr(b + 2, lo_of(n) >> 8);
            wr(b + 3, hi_of(n) & 255); wr(b + 4, hi_of(n) >> 8);
            wr(b + 5, ival_of(n));
            wr(b + 6, ctl_of(n));
            wr(b + 7, en_b[n]);
        end
        // R1: readback of every slot byte.
        for (int n = 0; n < 8; n++) begin
            automatic int b = 'h60 + 8 * n;
            rd_chk(b + 0, 'h20 + n, "R1 sel");
            rd_chk(b + 2, lo_of(n) >> 8, "R1 lo hi byte");
            rd_chk(b + 3, hi_of(n) & 255, "R1 hi lo byte");
            rd_chk(b + 5, ival_of(n), "R1 ival");
            rd_chk(b + 7, en_b[n], "R1 enable");
        end

        // R2: no requests before enable, nor with enable but no start.
        pulse_tick();
        wr('h46, 'h80);
        pulse_tick();
        chk(ord_n == 0, "R2 no req before start", ord_n, 0);
        wr('h47, 'h80);
        rd_chk('h47, 'h80, "R2 start latched");

        // R3/R4: six ticks, order checked against computed timer fires.
        for (int t = 1; t <= 6; t++) begin
            automatic int base = ord_n;
            automatic int e = 0;
            automatic bit ok = 1;
            pulse_tick();
            for (int n = 0; n < 8; n++) begin
                automatic int iv = ival_of(n);
                if (iv != 3 && (t % (iv + 1)) == 0) begin
                    if (base + e >= ord_n || ord[(base + e) % 256] != n) ok = 0;
                    e++;
                    if (code_of(n) < lo_of(n)) slo[n] = 1;
                    if (code_of(n) > hi_of(n)) shi[n] = 1;
                end
            end
            chk(ok && (ord_n - base) == e, "R4 R3 service order", ord_n - base, e);
        end
        t_num = 6;
        chk(fld_bad == 0, "R4 settle/cal fields", fld_bad, 0);
        chk(req_cnt[3] == 0 && req_cnt[7] == 0, "R3 ival 3 never sampled",
            req_cnt[3] + req_cnt[7], 0);

        // R5/R6 incl. equality cases (ch1 at lower, ch4 at upper limit).
        rd_chk('h0A, slo, "R5 low status");
        rd_chk('h0B, shi, "R6 high status");
        chk(slo[1] == 0 && shi[4] == 0, "R5 R6 equal sets nothing", 0, 0);

        // R8: step through the gating terms.
        #1 chk(irq == exp_irq(), "R8 irq all enabled", int'(irq), int'(exp_irq()));
        en_b[0] = 'h82; wr('h67, en_b[0]);
        en_b[5] = 'h82; wr('h8F, en_b[5]);
        #1 chk(irq == exp_irq(), "R8 irq after low ie off", int'(irq), int'(exp_irq()));
        en_b[2] = 'h81; wr('h77, en_b[2]);
        #1 chk(irq == exp_irq(), "R8 irq all ie off", int'(irq), int'(exp_irq()));
        en_b[6] = 'h02; wr('h97, en_b[6]);
        #1 chk(irq == exp_irq(), "R8 irq meas off", int'(irq), int'(exp_irq()));
        en_b[6] = 'h82; wr('h97, en_b[6]);
        #1 chk(irq == exp_irq(), "R8 irq ch6 high", int'(irq), int'(exp_irq()));

        // R7: zero write keeps, one write clears.
        wr('h0A, 0);
        rd_chk('h0A, slo, "R7 zero write keeps");
        wr('h0B, 'h40);
        shi[6] = 0;
        rd_chk('h0B, shi, "R7 w1c high");
        #1 chk(irq == exp_irq(), "R8 irq after clear", int'(irq), int'(exp_irq()));

        // R9: measurement disabled channel is skipped while its timer fires.
        begin
            automatic int c6 = req_cnt[6];
            automatic int c2 = req_cnt[2];
            en_b[6] = 'h00; wr('h97, 0);
            for (int t = 7; t <= 9; t++) pulse_tick();
            chk(req_cnt[6] == c6, "R9 disabled not requested", req_cnt[6], c6);
            chk(req_cnt[2] == c2 + 1, "R3 timer 3 still fires", req_cnt[2], c2 + 1);
        end

        // R2: clearing global enable stops monitoring.
        begin
            automatic int c = ord_n;
            wr('h46, 0);
            rd_chk('h47, 0, "R2 start dropped");
            pulse_tick();
            pulse_tick();
            chk(ord_n == c, "R2 no req after disable", ord_n, c);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule